// File: doc/BRIEF.md
# UART Serial Transmitter

This block is the transmit half of an asynchronous serial port. It runs from a reference clock at sixteen times the bit rate. A host places a byte on an 8-bit bus and pulses an active-low load strobe. While the strobe is low, the byte is taken into a holding buffer. When the strobe rises, the byte is queued for sending. The block then sends it on a single line as a low start bit, the data bits least significant first, an optional parity bit and the stop bits.

The character format can be changed at run time. It is held in a small format register, which takes its value from dedicated pins on any clock edge where the format-load input is high. The format sets the word length (5 to 8 bits), whether a parity bit is sent, even or odd parity, and the stop length: 1 or 2 bits, or 1.5 bits for 5-bit words. Because the buffer and the shift register are separate, one byte can wait while another is being sent. Two flags show the host when the buffer has room and when the line has gone fully quiet.

Top module: `uart_tx_core`

## Requirements
- R1: While `rst_i` is high, `txd_o`, `buf_empty_o` and `tx_empty_o` are all high at once, without waiting for a clock edge. Any frame in progress is dropped, and any byte waiting in the buffer is dropped. After reset is released, the line stays idle until a new load.
- R2: A frame is a low start bit, then the data bits, then the parity bit when enabled, then high stop bits. Every bit except a 1.5-bit stop lasts 16 reference cycles. Between frames the line rests high. `txd_o` comes straight from a register.
- R3: The length select sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bit 0 of the byte is sent first. Byte bits above the selected length are not sent.
- R4: When parity inhibit is high, no parity bit is sent. When it is low, one parity bit follows the data. With the even input high, that bit makes the count of ones among the active data bits plus the parity bit even. With the even input low, it makes that count odd.
- R5: The stop length is 16 cycles when stop select is low. When stop select is high, it is 32 cycles, except with 5-bit words, where it is 24 cycles. `tx_empty_o` rises exactly when the stop time ends.
- R6: The format pins are taken into the format register only on a clock edge where `fmt_load_i` is high. Changing the pins at any other time has no effect on the next frame.
- R7: On every clock edge where `load_n_i` is low, `data_i` is captured, so the last value seen before the strobe rises is the one sent. `buf_empty_o` falls on the second clock edge after the strobe rises. The start bit appears one edge later when the line is idle.
- R8: `tx_empty_o` is low from the edge that starts a start bit until the edge that ends the last stop bit. The line is high whenever `tx_empty_o` is high.
- R9: A byte queued while a frame is in progress waits in the buffer. On the edge where the current stop time ends, it moves into the shift register. On that same edge its start bit begins and `buf_empty_o` rises. `tx_empty_o` stays low across the boundary.
- R10: The format is fixed when a byte moves into the shift register. A format load during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock at 16x the bit rate |
| rst_i | input | 1 | Master reset, active high, asynchronous |
| fmt_load_i | input | 1 | Format register write enable |
| len_sel_i | input | 2 | Data length select (0..3 for 5..8 bits) |
| par_inh_i | input | 1 | High: no parity bit |
| par_even_i | input | 1 | High: even parity, low: odd parity |
| stop_sel_i | input | 1 | High: long stop (2 bits, or 1.5 for 5-bit words) |
| load_n_i | input | 1 | Active-low buffer load strobe; its rising edge queues the byte |
| data_i | input | 8 | Byte to transmit |
| txd_o | output | 1 | Serial line output, idle high |
| buf_empty_o | output | 1 | Buffer can accept a new byte |
| tx_empty_o | output | 1 | No frame in progress |

## Verification
A table of eight formats covers every word length, both parity senses, inhibited parity and all three stop lengths. Its data values are chosen so that parity lands on both 0 and 1, and so that bits above the active length would show up if they were wrongly sent. Sampling each bit at its midpoint separates bit-order and length faults from parity faults. Counting cycles up to `tx_empty_o` separates the 16-, 24- and 32-cycle stop times. Directed cases then cover the following:
- a strobe held over changing data;
- a byte queued during a frame, checked for a gap-free hand-over;
- format pins changed without a load;
- a format load during a frame;
- a reset during a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef struct packed {
        logic [1:0] len;       // 0..3 selects 5..8 data bits
        logic       par_inh;   // no parity bit when set
        logic       par_even;  // even parity when set
        logic       stop_sel;  // long stop time when set
    } fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
    import uart_tx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  fmt_t fmt_i,
    output fmt_t fmt_o
);

    fmt_t fmt_d, fmt_q;

    always_comb begin
        fmt_d = fmt_q;
        if (load_i) begin
            fmt_d = fmt_i;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            fmt_q <= '0;
        end else begin
            fmt_q <= fmt_d;
        end
    end

    assign fmt_o = fmt_q;

    // R6
    fmt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(fmt_q));

endmodule

// File: rtl/uart_tx_strobe.sv
module uart_tx_strobe (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_n_i,
    output logic rise_o
);

    typedef struct packed {
        logic cur;   // strobe sampled on this edge
        logic prev;  // strobe sampled one edge earlier
    } strb_t;

    strb_t strb_d, strb_q;

    always_comb begin
        strb_d.cur  = load_n_i;
        strb_d.prev = strb_q.cur;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            strb_q <= '{cur: 1'b1, prev: 1'b1};
        end else begin
            strb_q <= strb_d;
        end
    end

    assign rise_o = strb_q.cur & ~strb_q.prev;

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  fmt_t              fmt_i,
    input  logic              load_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              start_i,
    output logic              txd_o,
    output logic              buf_empty_o,
    output logic              tx_empty_o
);

    localparam int CYC_W = $clog2(2 * OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CYC_W-1:0] BIT_LAST   = CYC_W'(OVERSAMPLE - 1);
    localparam logic [CYC_W-1:0] STOP15_LAST = CYC_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    localparam logic [CYC_W-1:0] STOP2_LAST = CYC_W'(2 * OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_BASE   = IDX_W'(DATA_W - 4);
    localparam logic [IDX_W:0]   CNT_BASE   = (IDX_W + 1)'(DATA_W - 3);

    typedef struct packed {
        tx_state_e         state;
        logic [CYC_W-1:0]  cyc;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shift;
        logic              full;
        logic              par;
        fmt_t              fmt;
        logic              txd;
        logic              empty;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [CYC_W-1:0]  stop_last;
    logic [IDX_W-1:0]  idx_last;
    logic [IDX_W:0]    act_cnt;
    logic [DATA_W-1:0] act_mask;
    logic              par_calc;
    logic              take;

    // stop time and last data index of the frame in flight
    always_comb begin
        if (!eng_q.fmt.stop_sel) begin
            stop_last = BIT_LAST;
        end else if (eng_q.fmt.len == 2'd0) begin
            stop_last = STOP15_LAST;
        end else begin
            stop_last = STOP2_LAST;
        end
        idx_last = IDX_BASE + IDX_W'(eng_q.fmt.len);
    end

    // parity of the buffered byte under the format about to be frozen
    always_comb begin
        act_cnt = CNT_BASE + (IDX_W + 1)'(fmt_i.len);
        for (int i = 0; i < DATA_W; i++) begin
            act_mask[i] = ((IDX_W + 1)'(i) < act_cnt);
        end
        par_calc = (^(eng_q.hold & act_mask)) ^ ~fmt_i.par_even;
    end

    always_comb begin
        eng_d = eng_q;
        take  = 1'b0;

        if (!load_n_i) begin
            eng_d.hold = data_i;
        end

        case (eng_q.state)
            ST_IDLE: begin
                take = eng_q.full;
            end
            ST_START: begin
                eng_d.cyc = eng_q.cyc + 1'b1;
                if (eng_q.cyc == BIT_LAST) begin
                    eng_d.state = ST_DATA;
                    eng_d.cyc   = '0;
                    eng_d.idx   = '0;
                end
            end
            ST_DATA: begin
                eng_d.cyc = eng_q.cyc + 1'b1;
                if (eng_q.cyc == BIT_LAST) begin
                    eng_d.cyc   = '0;
                    eng_d.shift = eng_q.shift >> 1;
                    if (eng_q.idx == idx_last) begin
                        eng_d.state = eng_q.fmt.par_inh ? ST_STOP : ST_PARITY;
                    end else begin
                        eng_d.idx = eng_q.idx + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                eng_d.cyc = eng_q.cyc + 1'b1;
                if (eng_q.cyc == BIT_LAST) begin
                    eng_d.state = ST_STOP;
                    eng_d.cyc   = '0;
                end
            end
            ST_STOP: begin
                eng_d.cyc = eng_q.cyc + 1'b1;
                if (eng_q.cyc == stop_last) begin
                    eng_d.state = ST_IDLE;
                    eng_d.cyc   = '0;
                    take        = eng_q.full;
                end
            end
            default: begin
                eng_d.state = ST_IDLE;
                eng_d.cyc   = '0;
            end
        endcase

        if (take) begin
            eng_d.state = ST_START;
            eng_d.cyc   = '0;
            eng_d.idx   = '0;
            eng_d.shift = eng_q.hold;
            eng_d.fmt   = fmt_i;
            eng_d.par   = par_calc;
            eng_d.full  = 1'b0;
        end

        if (start_i) begin
            eng_d.full = 1'b1;
        end

        case (eng_d.state)
            ST_START:  eng_d.txd = 1'b0;
            ST_DATA:   eng_d.txd = eng_d.shift[0];
            ST_PARITY: eng_d.txd = eng_d.par;
            default:   eng_d.txd = 1'b1;
        endcase
        eng_d.empty = (eng_d.state == ST_IDLE);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            eng_q <= '{state: ST_IDLE, cyc: '0, idx: '0, hold: '0, shift: '0,
                       full: 1'b0, par: 1'b0, fmt: '0, txd: 1'b1, empty: 1'b1};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign txd_o       = eng_q.txd;
    assign buf_empty_o = ~eng_q.full;
    assign tx_empty_o  = eng_q.empty;

    // R8
    idle_line_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_empty_o |-> txd_o);

    // R8
    start_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(tx_empty_o) |-> !txd_o);

    // R9
    handover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(buf_empty_o) |-> !tx_empty_o && !txd_o);

    // R5
    stop_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (eng_q.state == ST_STOP) |-> (eng_q.cyc <= stop_last));

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fmt_load_i,
    input  logic [1:0]        len_sel_i,
    input  logic              par_inh_i,
    input  logic              par_even_i,
    input  logic              stop_sel_i,
    input  logic              load_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              txd_o,
    output logic              buf_empty_o,
    output logic              tx_empty_o
);

    fmt_t fmt_pins;
    fmt_t fmt_cur;
    logic strobe_rise;

    assign fmt_pins = '{len: len_sel_i, par_inh: par_inh_i,
                        par_even: par_even_i, stop_sel: stop_sel_i};

    uart_tx_fmt i_fmt (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (fmt_load_i),
        .fmt_i  (fmt_pins),
        .fmt_o  (fmt_cur)
    );

    uart_tx_strobe i_strobe (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_n_i (load_n_i),
        .rise_o   (strobe_rise)
    );

    uart_tx_engine #(
        .DATA_W     (DATA_W),
        .OVERSAMPLE (OVERSAMPLE)
    ) i_engine (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .fmt_i       (fmt_cur),
        .load_n_i    (load_n_i),
        .data_i      (data_i),
        .start_i     (strobe_rise),
        .txd_o       (txd_o),
        .buf_empty_o (buf_empty_o),
        .tx_empty_o  (tx_empty_o)
    );

    // R7
    load_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(buf_empty_o) |-> $past(load_n_i, 2) && !$past(load_n_i, 3));

endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fmt_load = 1'b0;
    logic [1:0] len_sel = 2'd3;
    logic       par_inh = 1'b1;
    logic       par_even = 1'b0;
    logic       stop_sel = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] data = 8'h00;
    logic       txd, buf_empty, tx_empty;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk_i       (clk),
        .rst_i       (rst),
        .fmt_load_i  (fmt_load),
        .len_sel_i   (len_sel),
        .par_inh_i   (par_inh),
        .par_even_i  (par_even),
        .stop_sel_i  (stop_sel),
        .load_n_i    (load_n),
        .data_i      (data),
        .txd_o       (txd),
        .buf_empty_o (buf_empty),
        .tx_empty_o  (tx_empty)
    );

    // fields: {len[1:0], par_inh, par_even, stop_sel, data[7:0]}
    localparam logic [12:0] VECS [8] = '{
        {2'd3, 1'b0, 1'b1, 1'b0, 8'hA5},
        {2'd3, 1'b1, 1'b0, 1'b0, 8'h3C},
        {2'd0, 1'b0, 1'b0, 1'b1, 8'hFF},
        {2'd1, 1'b0, 1'b1, 1'b1, 8'hED},
        {2'd2, 1'b0, 1'b1, 1'b0, 8'h81},
        {2'd0, 1'b1, 1'b0, 1'b0, 8'hEA},
        {2'd2, 1'b1, 1'b1, 1'b1, 8'h55},
        {2'd3, 1'b0, 1'b0, 1'b1, 8'h00}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fmt(input logic [1:0] l, input logic pi, input logic pe, input logic ss);
        @(negedge clk);
        len_sel = l; par_inh = pi; par_even = pe; stop_sel = ss; fmt_load = 1'b1;
        @(negedge clk);
        fmt_load = 1'b0;
    endtask

    task automatic pins_only(input logic [1:0] l, input logic pi, input logic pe, input logic ss);
        len_sel = l; par_inh = pi; par_even = pe; stop_sel = ss;
    endtask

    task automatic strobe(input logic [7:0] d);
        @(negedge clk);
        load_n = 1'b0; data = d;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    // called at the negedge where load_n was raised on an idle line; returns at k=0
    task automatic after_rise();
        @(negedge clk);
        check(buf_empty == 1'b1, "R7 buf_empty one edge after rise", buf_empty, 1);
        @(negedge clk);
        check(buf_empty == 1'b0, "R7 buf_empty two edges after rise", buf_empty, 0);
        check(tx_empty == 1'b1, "R8 still idle before start", tx_empty, 1);
        @(negedge clk);
        check(tx_empty == 1'b0 && txd == 1'b0, "R8 start bit begins", {tx_empty, txd}, 0);
    endtask

    // starts at k=0 (first negedge of the start bit)
    task automatic expect_frame(input logic [1:0] l, input logic pi, input logic pe,
                                input logic ss, input logic [7:0] d, input logic to_idle);
        int nd, nb, sl, total, ones, k;
        logic pbit;
        nd = 5 + int'(l);
        ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(d[i]);
        pbit = pe ? ones[0] : ~ones[0];
        nb = 1 + nd + (pi ? 0 : 1);
        sl = !ss ? 16 : (l == 2'd0 ? 24 : 32);
        total = 16 * nb + sl;
        repeat (8) @(negedge clk);
        check(txd == 1'b0, "R2 start bit low", txd, 0);
        for (int i = 0; i < nd; i++) begin
            repeat (16) @(negedge clk);
            check(txd == d[i], "R3 data bit", txd, d[i]);
        end
        if (!pi) begin
            repeat (16) @(negedge clk);
            check(txd == pbit, "R4 parity bit", txd, pbit);
        end
        repeat (16) @(negedge clk);
        check(txd == 1'b1 && tx_empty == 1'b0, "R5 stop bit high", {txd, tx_empty}, 2);
        if (to_idle) begin
            k = 16 * nb + 8;
            while (tx_empty == 1'b0 && k < 400) begin
                @(negedge clk);
                k++;
            end
            check(k == total, "R5 frame length", k, total);
            check(txd == 1'b1, "R2 idle high after frame", txd, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txd && buf_empty && tx_empty, "R1 reset state", {txd, buf_empty, tx_empty}, 7);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // table of formats
        for (int v = 0; v < 8; v++) begin
            set_fmt(VECS[v][12:11], VECS[v][10], VECS[v][9], VECS[v][8]);
            strobe(VECS[v][7:0]);
            after_rise();
            expect_frame(VECS[v][12:11], VECS[v][10], VECS[v][9], VECS[v][8], VECS[v][7:0], 1'b1);
            repeat (3) @(negedge clk);
        end

        // R7: data changes while strobe held low; last value wins
        set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        load_n = 1'b0; data = 8'h11;
        @(negedge clk);
        data = 8'hE7;
        @(negedge clk);
        load_n = 1'b1;
        after_rise();
        expect_frame(2'd3, 1'b1, 1'b0, 1'b0, 8'hE7, 1'b1);

        // R9: byte queued mid-frame, gap-free hand-over
        strobe(8'h96);
        after_rise();
        repeat (20) @(negedge clk);
        strobe(8'h4B);
        repeat (3) @(negedge clk);
        check(buf_empty == 1'b0, "R9 queued byte holds buffer", buf_empty, 0);
        repeat (134) @(negedge clk);
        check(!buf_empty && !tx_empty && txd, "R9 last stop cycle", {buf_empty, tx_empty, txd}, 1);
        @(negedge clk);
        check(buf_empty && !tx_empty && !txd, "R9 transfer edge", {buf_empty, tx_empty, txd}, 4);
        expect_frame(2'd3, 1'b1, 1'b0, 1'b0, 8'h4B, 1'b1);

        // R6: pins changed without load have no effect
        pins_only(2'd0, 1'b0, 1'b1, 1'b1);
        strobe(8'h3C);
        after_rise();
        expect_frame(2'd3, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1);

        // R10: format load during a frame applies only to the next frame
        pins_only(2'd3, 1'b1, 1'b0, 1'b0);
        strobe(8'hC3);
        after_rise();
        fork
            begin
                repeat (50) @(negedge clk);
                set_fmt(2'd0, 1'b1, 1'b0, 1'b0);
            end
            expect_frame(2'd3, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1);
        join
        strobe(8'h0B);
        after_rise();
        expect_frame(2'd0, 1'b1, 1'b0, 1'b0, 8'h0B, 1'b1);

        // R1: reset mid-frame with a byte also queued
        set_fmt(2'd3, 1'b1, 1'b0, 1'b0);
        strobe(8'h00);
        after_rise();
        repeat (10) @(negedge clk);
        strobe(8'h5A);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        #1;
        check(txd && buf_empty && tx_empty, "R1 async reset mid-frame", {txd, buf_empty, tx_empty}, 7);
        @(negedge clk);
        rst = 1'b0;
        begin
            logic quiet;
            quiet = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!(txd && tx_empty && buf_empty)) quiet = 1'b0;
            end
            check(quiet, "R1 idle after reset release", quiet, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule